// File: doc/BRIEF.md
# Flexible Immediate Constant Expander

This combinational unit takes the 12-bit immediate field of an instruction and produces the 32-bit operand constant it stands for. An encoded immediate is either an 8-bit byte placed in one of four fixed layouts: alone in the low byte, copied into alternating bytes (two phases), or copied into every byte. Otherwise it is a byte with its top bit forced to one, rotated right inside the 32-bit word.

The unit also decides whether the carry flag is written. A write happens only when three things hold together: the instruction updates flags, it belongs to the logical or move class, and the constant came from the rotated form with a value above 255. The carry-out then equals bit 31 of the constant. In every other case the incoming carry passes through unchanged and the write enable stays low. A replicated layout whose byte is zero is an unpredictable encoding and is reported on a separate output.

Top module: `imm_expander`

## Requirements
- R1: With imm_i[11:8] = 0000, value_o equals imm_i[7:0] zero-extended to 32 bits.
- R2: With imm_i[11:8] = 0001 and byte XY = imm_i[7:0], value_o equals 0x00XY00XY.
- R3: With imm_i[11:8] = 0010, value_o equals 0xXY00XY00.
- R4: With imm_i[11:8] = 0011, value_o equals 0xXYXYXYXY.
- R5: With imm_i[11:10] not 00, value_o equals the 32-bit zero-extended byte {1, imm_i[6:0]} rotated right by imm_i[11:7] positions (a count from 8 to 31).
- R6: When flag_logic_i = 1 and the constant comes from the rotated form with a value above 255, carry_we_o = 1 and carry_o equals value_o[31].
- R7: In every other case (a replicated or plain form, or flag_logic_i = 0) carry_we_o = 0 and carry_o equals carry_i.
- R8: invalid_o = 1 exactly when imm_i[11:10] = 00, imm_i[9:8] is not 00 and imm_i[7:0] = 0; the plain form with a zero byte is valid.
- R9: The outputs are a pure function of the current inputs and need no clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_i | input | 12 | Encoded immediate field |
| carry_i | input | 1 | Current carry flag |
| flag_logic_i | input | 1 | Instruction sets flags and is of the logical or move class |
| value_o | output | 32 | Expanded constant |
| carry_o | output | 1 | Carry value to store |
| carry_we_o | output | 1 | Carry write enable |
| invalid_o | output | 1 | Unpredictable encoding (replicated zero byte) |

## Verification
Two functions coincide in the same cycle: the rotation of the byte and the carry decision that reads bit 31 of that same rotated result. The bench provokes this by sweeping every one of the 4096 encodings under all four combinations of carry_i and flag_logic_i. It judges each vector against its own model, where a carry write must show carry_o equal to the model's bit 31 while carry_i is driven to the opposite value. That separates a genuine write from a pass-through.

// File: rtl/imm_exp_pkg.sv
package imm_exp_pkg;

   typedef enum logic [2:0] {
      FORM_PLAIN = 3'd0,
      FORM_LO2   = 3'd1,
      FORM_HI2   = 3'd2,
      FORM_ALL4  = 3'd3,
      FORM_ROT   = 3'd4
   } imm_form_e;

endpackage

// File: rtl/imm_form_decode.sv
module imm_form_decode
   import imm_exp_pkg::*;
#(
   parameter int IMM_W  = 12,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic [IMM_W-1:0]  imm_i,
   output imm_form_e         form_o,
   output logic [BYTE_W-1:0] rep_byte_o,
   output logic [BYTE_W-1:0] rot_byte_o,
   output logic [CNT_W-1:0]  rot_cnt_o,
   output logic              invalid_o
);
   localparam int SEL_LO = IMM_W - 2;

   generate
      if (IMM_W != BYTE_W - 1 + CNT_W) begin : g_bad_imm_w
         $error("imm_form_decode: IMM_W must equal BYTE_W-1+CNT_W");
      end
      if (SEL_LO < BYTE_W + 2) begin : g_bad_sel
         $error("imm_form_decode: selector field overlaps layout field");
      end
   endgenerate

   logic rotated;
   assign rotated = |imm_i[IMM_W-1:SEL_LO];

   always_comb begin
      if (rotated) begin
         form_o = FORM_ROT;
      end else begin
         unique case (imm_i[BYTE_W+1:BYTE_W])
            2'b00:   form_o = FORM_PLAIN;
            2'b01:   form_o = FORM_LO2;
            2'b10:   form_o = FORM_HI2;
            default: form_o = FORM_ALL4;
         endcase
      end
   end

   assign rep_byte_o = imm_i[BYTE_W-1:0];
   assign rot_byte_o = {1'b1, imm_i[BYTE_W-2:0]};
   assign rot_cnt_o  = imm_i[IMM_W-1:BYTE_W-1];
   assign invalid_o  = !rotated && (|imm_i[BYTE_W+1:BYTE_W]) && (imm_i[BYTE_W-1:0] == '0);

   always_comb begin
      // R8
      invalid_form_chk: assert (!invalid_o || (form_o != FORM_PLAIN && form_o != FORM_ROT));
   end
endmodule

// File: rtl/imm_rotator.sv
module imm_rotator #(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 5,
   parameter int ROT_STYLE = 0
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W-1:0] rot_o
);
   logic [DATA_W-1:0] seed;
   assign seed = {{(DATA_W-BYTE_W){1'b0}}, byte_i};

   generate
      if ((1 << CNT_W) != DATA_W) begin : g_bad_cnt
         $error("imm_rotator: CNT_W must be log2(DATA_W)");
      end
      if (ROT_STYLE == 0) begin : g_log
         logic [DATA_W-1:0] stage [0:CNT_W];
         assign stage[0] = seed;
         for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = cnt_i[s] ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
                                         : stage[s];
         end
         assign rot_o = stage[CNT_W];
      end else begin : g_wide
         logic [2*DATA_W-1:0] dbl;
         assign dbl   = {seed, seed} >> cnt_i;
         assign rot_o = dbl[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      // R5
      rot_bits_kept_chk: assert ($countones(rot_o) == $countones(byte_i));
   end
endmodule

// File: rtl/imm_replicate.sv
module imm_replicate
   import imm_exp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  imm_form_e         form_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [DATA_W-1:0] rep_o
);
   localparam int LANES = DATA_W / BYTE_W;

   generate
      if (LANES * BYTE_W != DATA_W || LANES != 4) begin : g_bad_lanes
         $error("imm_replicate: DATA_W must hold exactly four bytes");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic lane_on;
         always_comb begin
            unique case (form_i)
               FORM_PLAIN: lane_on = (k == 0);
               FORM_LO2:   lane_on = (k % 2 == 0);
               FORM_HI2:   lane_on = (k % 2 == 1);
               FORM_ALL4:  lane_on = 1'b1;
               default:    lane_on = 1'b0;
            endcase
         end
         assign rep_o[k*BYTE_W +: BYTE_W] = lane_on ? byte_i : '0;
      end
   endgenerate
endmodule

// File: rtl/imm_carry_ctl.sv
module imm_carry_ctl #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] value_i,
   input  logic              rotated_i,
   input  logic              flag_logic_i,
   input  logic              carry_i,
   output logic              carry_o,
   output logic              carry_we_o
);
   logic above_byte;
   assign above_byte = |value_i[DATA_W-1:BYTE_W];
   assign carry_we_o = flag_logic_i && rotated_i && above_byte;
   assign carry_o    = carry_we_o ? value_i[DATA_W-1] : carry_i;
endmodule

// File: rtl/imm_expander.sv
module imm_expander
   import imm_exp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int IMM_W     = 12,
   parameter int ROT_STYLE = 0
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              carry_i,
   input  logic              flag_logic_i,
   output logic [DATA_W-1:0] value_o,
   output logic              carry_o,
   output logic              carry_we_o,
   output logic              invalid_o
);
   localparam int CNT_W = $clog2(DATA_W);

   generate
      if (ROT_STYLE != 0 && ROT_STYLE != 1) begin : g_bad_style
         $error("imm_expander: ROT_STYLE must be 0 or 1");
      end
   endgenerate

   imm_form_e         form;
   logic [BYTE_W-1:0] rep_byte;
   logic [BYTE_W-1:0] rot_byte;
   logic [CNT_W-1:0]  rot_cnt;
   logic [DATA_W-1:0] rot_val;
   logic [DATA_W-1:0] rep_val;
   logic              is_rot;

   imm_form_decode #(.IMM_W(IMM_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dec (
      .imm_i      (imm_i),
      .form_o     (form),
      .rep_byte_o (rep_byte),
      .rot_byte_o (rot_byte),
      .rot_cnt_o  (rot_cnt),
      .invalid_o  (invalid_o)
   );

   imm_rotator #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .ROT_STYLE(ROT_STYLE)) u_rot (
      .byte_i (rot_byte),
      .cnt_i  (rot_cnt),
      .rot_o  (rot_val)
   );

   imm_replicate #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rep (
      .form_i (form),
      .byte_i (rep_byte),
      .rep_o  (rep_val)
   );

   assign is_rot  = (form == FORM_ROT);
   assign value_o = is_rot ? rot_val : rep_val;

   imm_carry_ctl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cy (
      .value_i      (value_o),
      .rotated_i    (is_rot),
      .flag_logic_i (flag_logic_i),
      .carry_i      (carry_i),
      .carry_o      (carry_o),
      .carry_we_o   (carry_we_o)
   );

   always_comb begin
      // R6
      carry_src_chk: assert (!carry_we_o || (flag_logic_i && imm_i[IMM_W-1:IMM_W-2] != 2'b00));
      // R6
      carry_bit_chk: assert (!carry_we_o || carry_o == value_o[DATA_W-1]);
      // R7
      carry_hold_chk: assert (carry_we_o || carry_o == carry_i);
      // R8
      invalid_zero_chk: assert (!invalid_o || value_o == '0);
   end
endmodule

// File: tb/imm_expander_tb.sv
module imm_expander_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] imm = '0;
   logic        cin = 1'b0;
   logic        flog = 1'b0;
   logic [31:0] value;
   logic        cout, cwe, inval;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [11:0] imm;
      logic        cin;
      logic        flog;
      logic [31:0] val;
      logic        cout;
      logic        cwe;
      logic        inval;
   } item_t;

   item_t sb[$];

   always #2.5 clk = ~clk;

   imm_expander u_dut (
      .imm_i        (imm),
      .carry_i      (cin),
      .flag_logic_i (flog),
      .value_o      (value),
      .carry_o      (cout),
      .carry_we_o   (cwe),
      .invalid_o    (inval)
   );

   function automatic item_t model(logic [11:0] i, logic c, logic f);
      item_t e;
      logic [7:0]  xy;
      logic [31:0] r;
      e.imm = i; e.cin = c; e.flog = f;
      xy = i[7:0];
      e.inval = 1'b0;
      if (i[11:10] == 2'b00) begin
         case (i[9:8])
            2'b00: e.val = {24'h0, xy};
            2'b01: e.val = {8'h0, xy, 8'h0, xy};
            2'b10: e.val = {xy, 8'h0, xy, 8'h0};
            default: e.val = {xy, xy, xy, xy};
         endcase
         e.inval = (i[9:8] != 2'b00) && (xy == 8'h0);
         e.cwe  = 1'b0;
         e.cout = c;
      end else begin
         r = {24'h0, 1'b1, i[6:0]};
         for (int k = 0; k < int'(i[11:7]); k++) r = {r[0], r[31:1]};
         e.val  = r;
         e.cwe  = f && (r > 32'd255);
         e.cout = e.cwe ? r[31] : c;
      end
      return e;
   endfunction

   function automatic string tag(logic [11:0] i);
      if (i[11:10] != 2'b00) return "R5";
      case (i[9:8])
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic drive(logic [11:0] i, logic c, logic f);
      @(negedge clk);
      imm = i; cin = c; flog = f;
      sb.push_back(model(i, c, f));
   endtask

   // monitor: compare at the rising edge, half a period after the drive (R9: no cycle needed)
   always @(posedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t e;
         string cy;
         e = sb.pop_front();
         cy = e.cwe ? "R6" : "R7";
         checks++;
         if (value !== e.val) begin
            errors++;
            $display("FAIL %s imm=%h value actual=%h expected=%h", tag(e.imm), e.imm, value, e.val);
         end
         checks++;
         if (cwe !== e.cwe) begin
            errors++;
            $display("FAIL %s imm=%h f=%b carry_we actual=%b expected=%b", cy, e.imm, e.flog, cwe, e.cwe);
         end
         checks++;
         if (cout !== e.cout) begin
            errors++;
            $display("FAIL %s imm=%h cin=%b carry actual=%b expected=%b", cy, e.imm, e.cin, cout, e.cout);
         end
         checks++;
         if (inval !== e.inval) begin
            errors++;
            $display("FAIL R8 imm=%h invalid actual=%b expected=%b", e.imm, inval, e.inval);
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      // reset state: all-zero inputs give a zero constant, no write, valid (R1, R7, R8)
      @(negedge clk);
      checks++;
      if (value !== 32'h0 || cwe !== 1'b0 || cout !== 1'b0 || inval !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset-state actual=%h/%b/%b/%b expected=0/0/0/0", value, cwe, cout, inval);
      end
      rst = 1'b0;
      // corner vectors first: R8 zero byte, R5 counts 8 and 31, R6 bit31 with opposite carry
      drive(12'h100, 1'b1, 1'b1);
      drive(12'h000, 1'b1, 1'b1);
      drive(12'h400, 1'b0, 1'b1);
      drive(12'hFFF, 1'b1, 1'b1);
      drive(12'hF80, 1'b1, 1'b0);
      // exhaustive sweep of every encoding under all carry / flag combinations
      for (int i = 0; i < 4096; i++) begin
         for (int m = 0; m < 4; m++) begin
            drive(12'(i), m[0], m[1]);
         end
      end
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule